// File: doc/BRIEF.md
# RDS Bit Buffer with Dual-Mode Readout

This block sits behind an RDS demodulator. It keeps the decoded data bits in a small circular memory and hands them to a host controller over a two-wire clock and data link. A bit is accepted on a one-cycle strobe. No bit is stored after a reset or a clear until the demodulator reports a block identifier. From then on every bit is stored, whatever the later identifier state.

Two select pins choose how the host reads. In master readout the block drives the link clock itself. It sends one low-going clock pulse per stored bit, and the host samples data on the falling edge. In slave readout the host drives the clock. Each falling edge of that clock, brought through a synchronizer, consumes one bit. An active-low open-drain flag tells the host that unread bits are waiting. Both readout modes share one read pointer, so switching modes during a transfer neither skips nor repeats a bit. When the first select pin is high the block is frozen.

Top module: `rds_bitbuf`

## Requirements
- R1: Select code {cfg_tst,cfg_sel}=00 selects master readout, with hclk_oe=1. Code 01 selects slave readout, with hclk_oe=0.
- R2: After reset or after a clr pulse, strobed bits are discarded until id_pulse has been seen. After that, every strobed bit is stored regardless of later id_pulse activity.
- R3: The buffer holds DEPTH (default 128) bits. A bit written while it is full, with no read in the same cycle, replaces the oldest unread bit, and the occupancy stays at DEPTH.
- R4: In slave readout, flag_pull is 1 (line pulled low, meaning ready) exactly while at least one unread bit is stored, and dout shows the oldest unread bit.
- R5: In slave readout, each falling edge of hclk_i consumes one bit. When the last bit is consumed, flag_pull drops to 0 at the third rising system-clock edge after hclk_i goes low, and not earlier. A falling edge while the buffer is empty has no effect.
- R6: In master readout, while no identifier has been seen since reset or clear, hclk_o and dout stay at 1. Once one has been seen, flag_pull is 1.
- R7: In master readout, each stored bit produces one low pulse on hclk_o lasting exactly HALF_CYC cycles. dout carries that bit during the preceding high phase and throughout the low phase. Bits leave in arrival order.
- R8: If master readout last delivered bit n and the mode then changes to slave, slave readout starts with bit n+1.
- R9: clr clears the identifier state in both modes. In slave readout it also empties the buffer. In master readout stored bits are kept.
- R10: With cfg_tst=1, the stored bits, pointers and identifier state are frozen: strobes, id_pulse and hclk_i edges are ignored. In this state hclk_oe=0, dout=1 and flag_pull=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of identifier state (and of the buffer in slave readout) |
| cfg_tst | input | 1 | Select pin, high freezes the block |
| cfg_sel | input | 1 | Select pin, 0 master readout, 1 slave readout |
| bit_vld | input | 1 | One-cycle strobe for a demodulated bit |
| bit_val | input | 1 | Value of the strobed bit |
| id_pulse | input | 1 | Block identifier detected |
| hclk_i | input | 1 | Link clock from the host (slave readout) |
| hclk_o | output | 1 | Link clock driven by the block (master readout) |
| hclk_oe | output | 1 | Output enable for the link clock pad |
| dout | output | 1 | Link data line |
| flag_pull | output | 1 | 1 pulls the open-drain ID/ready line low |

## Verification
The checker watches properties on every cycle:
- occupancy never exceeds DEPTH;
- occupancy never rises while no identifier has been seen;
- a full buffer stays full on a write that has no matching read;
- a read is never issued against an empty buffer;
- the freeze keeps the occupancy fixed;
- the idle-high link in master readout before an identifier.

Some behaviours only the bench scenarios can show. These are the exact bit order and the values delivered, the flag release three edges after the host clock falls, and the width of the master clock pulse. They also include the continuation at bit n+1 across a mode switch and the bits kept over a clear in master readout.

// File: rtl/rds_bitbuf_pkg.sv
package rds_bitbuf_pkg;

    typedef enum logic [1:0] {
        RM_MASTER  = 2'b00,
        RM_SLAVE   = 2'b01,
        RM_STANDBY = 2'b10,
        RM_TEST    = 2'b11
    } rd_mode_e;

    typedef enum logic [1:0] {
        MC_IDLE = 2'd0,
        MC_HIGH = 2'd1,
        MC_LOW  = 2'd2
    } mclk_state_e;

endpackage

// File: rtl/rds_edge_sync.sv
module rds_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic fall
);
    // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];

endmodule

// File: rtl/rds_bit_fifo.sv
module rds_bit_fifo #(
    parameter int DEPTH = 128,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          flush,
    input  logic          wr_en,
    input  logic          wr_bit,
    input  logic          rd_en,
    output logic          head_bit,
    output logic [CW-1:0] count,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH-1:0] mem;
        logic [AW-1:0]    wr_ptr;
        logic [AW-1:0]    rd_ptr;
        logic [CW-1:0]    count;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    logic do_rd, drop;

    always_comb begin
        st_d  = st_q;
        do_rd = 1'b0;
        drop  = 1'b0;
        if (!hold) begin
            if (flush) begin
                st_d.wr_ptr = '0;
                st_d.rd_ptr = '0;
                st_d.count  = '0;
            end else begin
                do_rd = rd_en && (st_q.count != '0);
                drop  = wr_en && !do_rd && (st_q.count == CW'(DEPTH));
                if (wr_en) begin
                    st_d.mem[st_q.wr_ptr] = wr_bit;
                    st_d.wr_ptr           = ptr_next(st_q.wr_ptr);
                end
                if (do_rd || drop) st_d.rd_ptr = ptr_next(st_q.rd_ptr);
                if (wr_en && !do_rd && !drop) st_d.count = st_q.count + CW'(1);
                else if (!wr_en && do_rd)     st_d.count = st_q.count - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_bit = st_q.mem[st_q.rd_ptr];
    assign count    = st_q.count;
    assign empty    = (st_q.count == '0);

endmodule

// File: rtl/rds_master_clkgen.sv
module rds_master_clkgen
    import rds_bitbuf_pkg::*;
#(
    parameter int HALF_CYC = 8,
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic avail,
    input  logic head_bit,
    output logic clk_o,
    output logic data_o,
    output logic pop
);
    typedef struct packed {
        mclk_state_e   state;
        logic [CW-1:0] cnt;
        logic          data;
    } mc_st_t;

    mc_st_t st_d, st_q;
    logic   last;

    always_comb begin
        st_d = st_q;
        pop  = 1'b0;
        last = (st_q.cnt == CW'(HALF_CYC - 1));
        if (clr) begin
            st_d.state = MC_IDLE;
            st_d.cnt   = '0;
            st_d.data  = 1'b1;
        end else if (!en) begin
            st_d.state = MC_IDLE;
            st_d.cnt   = '0;
        end else begin
            unique case (st_q.state)
                MC_IDLE: if (avail) begin
                    st_d.state = MC_HIGH;
                    st_d.cnt   = '0;
                    st_d.data  = head_bit;
                end
                MC_HIGH: if (last) begin
                    st_d.state = MC_LOW;
                    st_d.cnt   = '0;
                    pop        = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
                MC_LOW: if (last) begin
                    st_d.state = MC_IDLE;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
                default: st_d.state = MC_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= MC_IDLE;
            st_q.cnt   <= '0;
            st_q.data  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_o  = (st_q.state != MC_LOW);
    assign data_o = st_q.data;

endmodule

// File: rtl/rds_bitbuf.sv
module rds_bitbuf
    import rds_bitbuf_pkg::*;
#(
    parameter int DEPTH       = 128,
    parameter int HALF_CYC    = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cfg_tst,
    input  logic cfg_sel,
    input  logic bit_vld,
    input  logic bit_val,
    input  logic id_pulse,
    input  logic hclk_i,
    output logic hclk_o,
    output logic hclk_oe,
    output logic dout,
    output logic flag_pull
);
    typedef struct packed {
        logic id_seen;
    } top_st_t;

    top_st_t  st_d, st_q;
    rd_mode_e mode;
    logic     is_master, is_slave, frozen;
    logic     host_fall, m_pop, m_clk, m_data;
    logic     wr_en, rd_en, flush, id_seen;
    logic     head_bit, fifo_empty;
    logic [CW-1:0] fifo_count;

    always_comb begin
        mode      = rd_mode_e'({cfg_tst, cfg_sel});
        is_master = (mode == RM_MASTER);
        is_slave  = (mode == RM_SLAVE);
        frozen    = cfg_tst;
    end

    always_comb begin
        st_d = st_q;
        if (clr)          st_d.id_seen = 1'b0;
        else if (!frozen) st_d.id_seen = st_q.id_seen | id_pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign id_seen = st_q.id_seen;
    assign wr_en   = bit_vld && st_q.id_seen && !frozen;
    assign flush   = clr && is_slave;
    assign rd_en   = is_slave ? (host_fall && !fifo_empty) : (is_master && m_pop);

    rds_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (hclk_i),
        .fall     (host_fall)
    );

    rds_bit_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (frozen),
        .flush    (flush),
        .wr_en    (wr_en),
        .wr_bit   (bit_val),
        .rd_en    (rd_en),
        .head_bit (head_bit),
        .count    (fifo_count),
        .empty    (fifo_empty)
    );

    rds_master_clkgen #(.HALF_CYC(HALF_CYC)) u_mclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .en       (is_master && st_q.id_seen && !clr),
        .avail    (!fifo_empty),
        .head_bit (head_bit),
        .clk_o    (m_clk),
        .data_o   (m_data),
        .pop      (m_pop)
    );

    always_comb begin
        hclk_o    = m_clk;
        hclk_oe   = is_master;
        dout      = 1'b1;
        flag_pull = 1'b0;
        if (is_master) begin
            dout      = m_data;
            flag_pull = st_q.id_seen;
        end else if (is_slave) begin
            dout      = fifo_empty ? 1'b1 : head_bit;
            flag_pull = !fifo_empty;
        end
    end

endmodule

// File: rtl/rds_bitbuf_chk.sv
module rds_bitbuf_chk #(
    parameter int DEPTH = 128,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr,
    input logic          cfg_tst,
    input logic          cfg_sel,
    input logic          id_seen,
    input logic          wr_en,
    input logic          rd_en,
    input logic          empty,
    input logic [CW-1:0] count,
    input logic          hclk_o,
    input logic          dout
);
    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    p_gate_before_id_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !id_seen |=> count <= $past(count));

    p_full_overwrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH) && wr_en && !rd_en && !clr && !cfg_tst) |=> count == CW'(DEPTH));

    p_read_needs_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);

    p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_tst |=> $stable(count));

    p_master_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_tst && !cfg_sel && !id_seen) |-> (hclk_o && dout));

endmodule

bind rds_bitbuf rds_bitbuf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .cfg_tst (cfg_tst),
    .cfg_sel (cfg_sel),
    .id_seen (id_seen),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .empty   (fifo_empty),
    .count   (fifo_count),
    .hclk_o  (hclk_o),
    .dout    (dout)
);

// File: tb/tb_rds_bitbuf.sv
module tb_rds_bitbuf;
    localparam int DEPTH = 128;
    localparam int HALF  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0, cfg_tst = 1'b0, cfg_sel = 1'b0;
    logic bit_vld = 1'b0, bit_val = 1'b0, id_pulse = 1'b0, hclk_i = 1'b0;
    logic hclk_o, hclk_oe, dout, flag_pull;

    int checks = 0;
    int errors = 0;
    bit model_q[$];
    bit model_id = 1'b0;

    always #4 clk = ~clk;

    rds_bitbuf #(.DEPTH(DEPTH), .HALF_CYC(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_tst(cfg_tst), .cfg_sel(cfg_sel),
        .bit_vld(bit_vld), .bit_val(bit_val), .id_pulse(id_pulse), .hclk_i(hclk_i),
        .hclk_o(hclk_o), .hclk_oe(hclk_oe), .dout(dout), .flag_pull(flag_pull)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic bit slave_now();
        return !cfg_tst && cfg_sel;
    endfunction

    task automatic push(input bit b);
        bit_vld = 1'b1;
        bit_val = b;
        tick();
        bit_vld = 1'b0;
        if (model_id && !cfg_tst) begin
            if (model_q.size() == DEPTH) void'(model_q.pop_front());
            model_q.push_back(b);
        end
    endtask

    task automatic send_id();
        id_pulse = 1'b1;
        tick();
        id_pulse = 1'b0;
        if (!cfg_tst) model_id = 1'b1;
    endtask

    task automatic set_mode(input logic t, input logic s);
        cfg_tst = t;
        cfg_sel = s;
        tick();
    endtask

    task automatic do_clr();
        clr = 1'b1;
        tick();
        clr = 1'b0;
        model_id = 1'b0;
        if (slave_now()) model_q.delete();
    endtask

    // R4 / R5: one host clock cycle in slave readout
    task automatic slave_read();
        bit exp;
        bit last;
        exp  = model_q[0];
        last = (model_q.size() == 1);
        chk("R4 flag low while data waits", flag_pull, 1'b1);
        chk("R4 dout shows oldest bit", dout, exp);
        hclk_i = 1'b1;
        repeat (3) tick();
        hclk_i = 1'b0;
        tick();
        tick();
        if (last) chk("R5 flag not released before third edge", flag_pull, 1'b1);
        tick();
        if (last) chk("R5 flag released at third edge", flag_pull, 1'b0);
        void'(model_q.pop_front());
        tick();
    endtask

    // R7: watch the master clock, check pulses and data; stop after stop_at bits
    task automatic master_collect(input int cycles, input int stop_at, output int got);
        logic prev;
        logic hi_dout;
        int   low_run;
        bit   exp;
        got     = 0;
        low_run = 0;
        prev    = hclk_o;
        hi_dout = dout;
        for (int i = 0; i < cycles; i++) begin
            tick();
            if (prev && !hclk_o) begin
                low_run = 1;
                if (model_q.size() == 0) begin
                    chk("R7 no pulse without data", 1'b1, 1'b0);
                end else begin
                    exp = model_q.pop_front();
                    chk("R7 dout at falling edge", dout, exp);
                    chk("R7 dout set up during high phase", hi_dout, exp);
                end
                got++;
                if (got == stop_at) break;
            end else if (!hclk_o) begin
                low_run++;
                chk("R7 dout held in low phase", dout, hi_dout);
            end else if (!prev && hclk_o) begin
                chk_int("R7 low pulse width", low_run, HALF);
            end
            if (hclk_o) hi_dout = dout;
            prev = hclk_o;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1..R10 actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int got;
        void'($urandom(32'h1f2e3d4c));
        repeat (3) tick();
        // R1 / R6: reset state in master readout
        chk("R1 master drives clock", hclk_oe, 1'b1);
        chk("R6 clock idle high before id", hclk_o, 1'b1);
        chk("R6 data idle high before id", dout, 1'b1);
        chk("R6 flag released before id", flag_pull, 1'b0);
        rst_n = 1'b1;
        tick();

        // R1 / R2: slave readout, bits before the identifier are dropped
        set_mode(1'b0, 1'b1);
        chk("R1 slave releases clock", hclk_oe, 1'b0);
        for (int i = 0; i < 5; i++) push(1'($urandom));
        tick();
        chk("R2 no store before id", flag_pull, 1'b0);

        // R2 / R4 / R5: store and read after the identifier
        send_id();
        for (int i = 0; i < 10; i++) push(1'($urandom));
        send_id();
        push(1'b1);
        push(1'b0);
        while (model_q.size() > 0) slave_read();

        // R5: falling edge on empty buffer is ignored
        hclk_i = 1'b1;
        repeat (3) tick();
        hclk_i = 1'b0;
        repeat (5) tick();
        chk("R5 empty fall leaves flag released", flag_pull, 1'b0);
        push(1'b0);
        push(1'b1);
        tick();
        slave_read();
        slave_read();

        // R3: overflow drops the oldest bits
        for (int i = 0; i < DEPTH + 3; i++) push(1'(i % 3 == 0));
        chk_int("R3 model full", model_q.size(), DEPTH);
        while (model_q.size() > 0) slave_read();

        // R7: master streaming in order
        for (int i = 0; i < 6; i++) push(1'($urandom));
        cfg_sel = 1'b0;
        master_collect(250, 0, got);
        chk_int("R7 master pulses per bit", got, 6);
        chk("R6 flag low once id seen", flag_pull, 1'b1);

        // R8: continuity master -> slave
        set_mode(1'b0, 1'b1);
        for (int i = 0; i < 5; i++) push(1'($urandom));
        cfg_sel = 1'b0;
        master_collect(250, 2, got);
        cfg_sel = 1'b1;
        tick();
        chk_int("R8 bits left after switch", model_q.size(), 3);
        while (model_q.size() > 0) slave_read();

        // R9 / R2: clear in slave empties and re-gates
        for (int i = 0; i < 3; i++) push(1'b0);
        do_clr();
        tick();
        chk("R9 slave clear empties buffer", flag_pull, 1'b0);
        push(1'b0);
        tick();
        chk("R2 clear re-gates writes", flag_pull, 1'b0);

        // R9 / R6: clear in master keeps stored bits
        send_id();
        push(1'b1);
        push(1'b0);
        push(1'b1);
        cfg_sel = 1'b0;
        clr     = 1'b1;
        tick();
        clr      = 1'b0;
        model_id = 1'b0;
        repeat (20) tick();
        chk("R6 master clock idle after clear", hclk_o, 1'b1);
        chk("R6 master data idle after clear", dout, 1'b1);
        set_mode(1'b0, 1'b1);
        chk_int("R9 master clear keeps bits", model_q.size(), 3);
        while (model_q.size() > 0) slave_read();

        // R10: freeze
        send_id();
        push(1'b0);
        push(1'b1);
        set_mode(1'b1, 1'b0);
        push(1'b0);
        send_id();
        hclk_i = 1'b1;
        repeat (3) tick();
        hclk_i = 1'b0;
        repeat (4) tick();
        chk("R10 standby releases flag", flag_pull, 1'b0);
        chk("R10 standby data high", dout, 1'b1);
        chk("R10 standby clock not driven", hclk_oe, 1'b0);
        set_mode(1'b0, 1'b1);
        tick();
        chk_int("R10 frozen contents", model_q.size(), 2);
        while (model_q.size() > 0) slave_read();

        // random mix in slave readout
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom % 10);
            if (r < 5) push(1'($urandom));
            else if (r < 9 && model_q.size() > 0) slave_read();
            else if (r == 9) send_id();
            tick();
            chk("R4 flag tracks occupancy", flag_pull, model_q.size() != 0);
        end
        while (model_q.size() > 0) slave_read();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule